// File: doc/BRIEF.md
# Outstanding Transaction Throttle

This block sits between an upstream DMA engine and a downstream memory port. It tracks three classes of traffic in flight: loads, store commands and store data beats. Each class shows up only as an issue pulse when upstream sends one unit and a completion pulse when the memory side retires one. Data movement and addresses are handled elsewhere.

Each class has its own limit input. A limit outside the legal range for its class is clamped to the nearest legal value. The block keeps one outstanding count per class. It raises a per-class stall toward upstream once that count reaches the effective limit. An issue that arrives while its class is stalled is rejected and not counted. A completion in the same cycle frees a slot at once, so the stall drops combinationally in that cycle. Lowering a limit never cancels anything already in flight. The stall simply holds until completions drain the count below the new limit.

Top module: `thr_txn_throttle`

## Requirements
- R1: The load limit is a 4-bit value. The effective load limit is 1 for a value of 0, 8 for values 9 to 15, and the value itself for 1 to 8. `ld_stall` is 1 when the load count equals the effective limit and no load completion is present.
- R2: The store-command limit is a 2-bit value. A value of 0 acts as 1, and values 1 to 3 act as themselves. `sc_stall` follows the same rule as loads, using the store-command count.
- R3: The store-data limit is a 5-bit value. Values 0 to 15 act as 16, and values 16 to 31 act as themselves. `sd_stall` follows the same rule, using the store-data count.
- R4: A stall is a combinational function of the present count, limit and completion input. An issue pulse seen while the class is stalled is rejected, and the count does not rise.
- R5: A completion on a class whose count is at its limit clears that class's stall in the same cycle. An accepted issue together with a completion leaves the count unchanged.
- R6: An accepted issue raises the count by one at the next clock edge. A completion on a non-zero count lowers it by one. A completion while the count is zero is ignored.
- R7: When a limit is lowered below the present count, the count is kept. The stall stays asserted until the count minus any completion in that cycle falls below the new effective limit.
- R8: The three classes are independent. Traffic or a stall on one class changes neither the count nor the stall of another.
- R9: While `rst_n` is low, all counts are zero and all stalls are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_limit | input | 4 | Requested load limit (clamped) |
| sc_limit | input | 2 | Requested store-command limit (clamped) |
| sd_limit | input | 5 | Requested store-data limit (clamped) |
| ld_issue | input | 1 | One load sent upstream this cycle |
| ld_done | input | 1 | One load retired this cycle |
| sc_issue | input | 1 | One store command sent this cycle |
| sc_done | input | 1 | One store command retired this cycle |
| sd_issue | input | 1 | One store data beat sent this cycle |
| sd_done | input | 1 | One store data beat retired this cycle |
| ld_stall | output | 1 | Backpressure for loads |
| sc_stall | output | 1 | Backpressure for store commands |
| sd_stall | output | 1 | Backpressure for store data |
| ld_count | output | 4 | Loads outstanding |
| sc_count | output | 2 | Store commands outstanding |
| sd_count | output | 5 | Store data beats outstanding |

## Verification
Some properties are checked on every cycle. Each effective limit must stay inside its legal range. A count at or above its limit with no completion must stall. A stalled class must never grow. An accepted issue paired with a completion must hold the count, and a lone accepted issue must add exactly one. A class with no traffic must keep its count. Other behaviour can only be shown by the directed scenarios, because it needs particular values driven in a particular order. These are the exact clamped limit for out-of-range values such as 0, 12 and 5. They also include the same-cycle release of a stall by a completion, and the drain sequence after a limit is lowered below the count.

// File: rtl/thr_pkg.sv
package thr_pkg;

  // Clamp a requested limit into [lo, hi].
  function automatic int clamp_lim(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Count after one cycle with accepted issue and accepted completion.
  function automatic int next_count(int cnt, bit acc, bit ret);
    return cnt + int'(acc) - int'(ret);
  endfunction

  // Occupancy seen by the stall compare: completions free capacity at once.
  function automatic int pending(int cnt, bit ret);
    return cnt - int'(ret);
  endfunction

endpackage

// File: rtl/thr_limit_clamp.sv
module thr_limit_clamp #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 4,
  parameter int LO    = 1,
  parameter int HI    = 8
) (
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] eff
);
  always_comb begin
    eff = OUT_W'(thr_pkg::clamp_lim(int'(raw), LO, HI));
  end
endmodule

// File: rtl/thr_credit_counter.sv
module thr_credit_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] lim,
  input  logic             issue,
  input  logic             done,
  output logic             stall,
  output logic             acc,
  output logic             ret,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] pend;

  assign ret   = done && (cnt != '0);
  assign pend  = CNT_W'(thr_pkg::pending(int'(cnt), ret));
  assign stall = (pend >= lim);
  assign acc   = issue && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= CNT_W'(thr_pkg::next_count(int'(cnt), acc, ret));
  end
endmodule

// File: rtl/thr_txn_throttle.sv
module thr_txn_throttle #(
  parameter int LD_LIM_W = 4,
  parameter int LD_LO    = 1,
  parameter int LD_HI    = 8,
  parameter int SC_LIM_W = 2,
  parameter int SC_LO    = 1,
  parameter int SC_HI    = 3,
  parameter int SD_LIM_W = 5,
  parameter int SD_LO    = 16,
  parameter int SD_HI    = 31,
  localparam int LD_CW   = $clog2(LD_HI + 1),
  localparam int SC_CW   = $clog2(SC_HI + 1),
  localparam int SD_CW   = $clog2(SD_HI + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LD_LIM_W-1:0] ld_limit,
  input  logic [SC_LIM_W-1:0] sc_limit,
  input  logic [SD_LIM_W-1:0] sd_limit,
  input  logic                ld_issue,
  input  logic                ld_done,
  input  logic                sc_issue,
  input  logic                sc_done,
  input  logic                sd_issue,
  input  logic                sd_done,
  output logic                ld_stall,
  output logic                sc_stall,
  output logic                sd_stall,
  output logic [LD_CW-1:0]    ld_count,
  output logic [SC_CW-1:0]    sc_count,
  output logic [SD_CW-1:0]    sd_count
);
  // Named internal events, used by the bound checker.
  logic [LD_CW-1:0] ld_lim_eff;
  logic [SC_CW-1:0] sc_lim_eff;
  logic [SD_CW-1:0] sd_lim_eff;
  logic ld_acc, ld_ret, sc_acc, sc_ret, sd_acc, sd_ret;

  thr_limit_clamp #(.IN_W(LD_LIM_W), .OUT_W(LD_CW), .LO(LD_LO), .HI(LD_HI))
    u_ld_clamp (.raw(ld_limit), .eff(ld_lim_eff));
  thr_limit_clamp #(.IN_W(SC_LIM_W), .OUT_W(SC_CW), .LO(SC_LO), .HI(SC_HI))
    u_sc_clamp (.raw(sc_limit), .eff(sc_lim_eff));
  thr_limit_clamp #(.IN_W(SD_LIM_W), .OUT_W(SD_CW), .LO(SD_LO), .HI(SD_HI))
    u_sd_clamp (.raw(sd_limit), .eff(sd_lim_eff));

  thr_credit_counter #(.CNT_W(LD_CW)) u_ld_cnt (
    .clk(clk), .rst_n(rst_n), .lim(ld_lim_eff), .issue(ld_issue), .done(ld_done),
    .stall(ld_stall), .acc(ld_acc), .ret(ld_ret), .cnt(ld_count));
  thr_credit_counter #(.CNT_W(SC_CW)) u_sc_cnt (
    .clk(clk), .rst_n(rst_n), .lim(sc_lim_eff), .issue(sc_issue), .done(sc_done),
    .stall(sc_stall), .acc(sc_acc), .ret(sc_ret), .cnt(sc_count));
  thr_credit_counter #(.CNT_W(SD_CW)) u_sd_cnt (
    .clk(clk), .rst_n(rst_n), .lim(sd_lim_eff), .issue(sd_issue), .done(sd_done),
    .stall(sd_stall), .acc(sd_acc), .ret(sd_ret), .cnt(sd_count));
endmodule

// File: rtl/thr_throttle_chk.sv
module thr_throttle_chk #(
  parameter int LD_LO = 1, parameter int LD_HI = 8,
  parameter int SC_LO = 1, parameter int SC_HI = 3,
  parameter int SD_LO = 16, parameter int SD_HI = 31,
  parameter int LD_CW = 4, parameter int SC_CW = 2, parameter int SD_CW = 5
) (
  input logic clk,
  input logic rst_n,
  input logic [LD_CW-1:0] ld_eff,
  input logic [SC_CW-1:0] sc_eff,
  input logic [SD_CW-1:0] sd_eff,
  input logic [LD_CW-1:0] ld_cnt,
  input logic [SC_CW-1:0] sc_cnt,
  input logic [SD_CW-1:0] sd_cnt,
  input logic ld_stall, input logic sc_stall, input logic sd_stall,
  input logic ld_issue, input logic ld_done, input logic ld_acc, input logic ld_ret,
  input logic sc_issue, input logic sc_done,
  input logic sd_done
);
  a_r1_ld_eff_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ld_eff) >= LD_LO) && (int'(ld_eff) <= LD_HI));
  a_r2_sc_eff_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sc_eff) >= SC_LO) && (int'(sc_eff) <= SC_HI));
  a_r3_sd_eff_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sd_eff) >= SD_LO) && (int'(sd_eff) <= SD_HI));

  // R4 and R7: at or above the limit without a completion, the class stalls.
  a_r4_ld_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cnt >= ld_eff && !ld_done) |-> ld_stall);
  a_r4_sd_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cnt >= sd_eff && !sd_done) |-> sd_stall);
  a_r4_ld_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |=> ld_cnt <= $past(ld_cnt));
  a_r4_sc_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    sc_stall |=> sc_cnt <= $past(sc_cnt));
  a_r4_sd_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    sd_stall |=> sd_cnt <= $past(sd_cnt));

  a_r5_ld_swap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_acc && ld_ret) |=> ld_cnt == $past(ld_cnt));
  a_r6_ld_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_acc && !ld_ret) |=> int'(ld_cnt) == int'($past(ld_cnt)) + 1);
  a_r6_ld_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cnt == '0 && !ld_issue) |=> ld_cnt == '0);

  a_r8_sc_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sc_issue && !sc_done) |=> $stable(sc_cnt));
endmodule

bind thr_txn_throttle thr_throttle_chk #(
  .LD_LO(LD_LO), .LD_HI(LD_HI), .SC_LO(SC_LO), .SC_HI(SC_HI),
  .SD_LO(SD_LO), .SD_HI(SD_HI), .LD_CW(LD_CW), .SC_CW(SC_CW), .SD_CW(SD_CW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ld_eff(ld_lim_eff), .sc_eff(sc_lim_eff), .sd_eff(sd_lim_eff),
  .ld_cnt(ld_count), .sc_cnt(sc_count), .sd_cnt(sd_count),
  .ld_stall(ld_stall), .sc_stall(sc_stall), .sd_stall(sd_stall),
  .ld_issue(ld_issue), .ld_done(ld_done), .ld_acc(ld_acc), .ld_ret(ld_ret),
  .sc_issue(sc_issue), .sc_done(sc_done),
  .sd_done(sd_done)
);

// File: tb/tb_thr_txn_throttle.sv
module tb_thr_txn_throttle;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ld_limit = 4'd8;
  logic [1:0] sc_limit = 2'd3;
  logic [4:0] sd_limit = 5'd31;
  logic ld_issue = 0, ld_done = 0, sc_issue = 0, sc_done = 0, sd_issue = 0, sd_done = 0;
  logic ld_stall, sc_stall, sd_stall;
  logic [3:0] ld_count;
  logic [1:0] sc_count;
  logic [4:0] sd_count;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  thr_txn_throttle dut (
    .clk(clk), .rst_n(rst_n),
    .ld_limit(ld_limit), .sc_limit(sc_limit), .sd_limit(sd_limit),
    .ld_issue(ld_issue), .ld_done(ld_done), .sc_issue(sc_issue), .sc_done(sc_done),
    .sd_issue(sd_issue), .sd_done(sd_done),
    .ld_stall(ld_stall), .sc_stall(sc_stall), .sd_stall(sd_stall),
    .ld_count(ld_count), .sc_count(sc_count), .sd_count(sd_count));

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drain_all();
    ld_issue = 0; sc_issue = 0; sd_issue = 0;
    ld_done = 1; sc_done = 1; sd_done = 1;
    for (int i = 0; i < 40; i++) tick();
    ld_done = 0; sc_done = 0; sd_done = 0;
    tick();
  endtask

  task automatic t_reset();
    repeat (3) tick();
    #1;
    chk("R9", "ld_count", ld_count, 0);
    chk("R9", "sd_count", sd_count, 0);
    chk("R9", "stalls", {ld_stall, sc_stall, sd_stall}, 0);
    rst_n = 1;
    tick();
  endtask

  task automatic t_load_fill();
    ld_limit = 4'd3;
    for (int i = 0; i < 3; i++) begin ld_issue = 1; tick(); end
    ld_issue = 0; #1;
    chk("R6", "ld_count after 3 issues", ld_count, 3);
    chk("R1", "ld_stall at limit 3", ld_stall, 1);
    ld_issue = 1; tick(); tick(); #1;
    chk("R4", "ld_count after rejected issues", ld_count, 3);
    ld_done = 1; #1;
    chk("R5", "ld_stall released by done", ld_stall, 0);
    tick(); #1;
    chk("R5", "ld_count after issue+done", ld_count, 3);
    drain_all();
  endtask

  task automatic t_load_clamp();
    ld_limit = 4'd0; #1;
    chk("R1", "ld_stall limit0 count0", ld_stall, 0);
    ld_issue = 1; tick(); tick(); ld_issue = 0; #1;
    chk("R1", "ld_count limit0 acts as 1", ld_count, 1);
    chk("R1", "ld_stall limit0 count1", ld_stall, 1);
    ld_limit = 4'd12; #1;
    chk("R1", "ld_stall limit12 count1", ld_stall, 0);
    ld_issue = 1;
    for (int i = 0; i < 10; i++) tick();
    ld_issue = 0; #1;
    chk("R1", "ld_count limit12 acts as 8", ld_count, 8);
    chk("R1", "ld_stall at 8", ld_stall, 1);
    drain_all();
  endtask

  task automatic t_store_cmd();
    sc_limit = 2'd0;
    sc_issue = 1; tick(); tick(); sc_issue = 0; #1;
    chk("R2", "sc_count limit0 acts as 1", sc_count, 1);
    chk("R2", "sc_stall limit0", sc_stall, 1);
    sc_limit = 2'd3; #1;
    chk("R2", "sc_stall limit3 count1", sc_stall, 0);
    sc_issue = 1; tick(); tick(); tick(); sc_issue = 0; #1;
    chk("R2", "sc_count at limit3", sc_count, 3);
    chk("R2", "sc_stall at limit3", sc_stall, 1);
    chk("R8", "ld/sd unaffected", {ld_stall, sd_stall}, 0);
    chk("R8", "ld/sd counts zero", ld_count + sd_count, 0);
    drain_all();
  endtask

  task automatic t_store_data();
    sd_limit = 5'd5;
    sd_issue = 1;
    for (int i = 0; i < 20; i++) tick();
    sd_issue = 0; #1;
    chk("R3", "sd_count limit5 acts as 16", sd_count, 16);
    chk("R3", "sd_stall at 16", sd_stall, 1);
    sd_limit = 5'd31; #1;
    chk("R3", "sd_stall limit31 count16", sd_stall, 0);
    sd_issue = 1;
    for (int i = 0; i < 20; i++) tick();
    sd_issue = 0; #1;
    chk("R3", "sd_count at 31", sd_count, 31);
    chk("R3", "sd_stall at 31", sd_stall, 1);
    drain_all();
  endtask

  task automatic t_lower_limit();
    ld_limit = 4'd8;
    ld_issue = 1;
    for (int i = 0; i < 5; i++) tick();
    ld_issue = 0;
    ld_limit = 4'd2; #1;
    chk("R7", "ld_stall after lowering", ld_stall, 1);
    chk("R7", "ld_count kept", ld_count, 5);
    ld_issue = 1; tick(); tick(); ld_issue = 0; #1;
    chk("R7", "ld_count no growth", ld_count, 5);
    ld_done = 1; tick(); #1;
    chk("R7", "ld_stall with done at count4", ld_stall, 1);
    tick(); tick(); ld_done = 0; #1;
    chk("R7", "ld_count drained to 2", ld_count, 2);
    chk("R7", "ld_stall at count2 limit2", ld_stall, 1);
    ld_done = 1; #1;
    chk("R7", "ld_stall released by done", ld_stall, 0);
    tick(); ld_done = 0; #1;
    chk("R7", "ld_stall at count1 limit2", ld_stall, 0);
    drain_all();
  endtask

  task automatic t_done_zero();
    ld_limit = 4'd8;
    ld_done = 1; tick(); ld_done = 0; #1;
    chk("R6", "ld_count done at zero", ld_count, 0);
    ld_issue = 1; #1;
    chk("R6", "ld_count before edge", ld_count, 0);
    tick(); ld_issue = 0; #1;
    chk("R6", "ld_count one edge later", ld_count, 1);
    drain_all();
  endtask

  initial begin
    t_reset();
    t_load_fill();
    t_load_clamp();
    t_store_cmd();
    t_store_data();
    t_lower_limit();
    t_done_zero();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule